// File: doc/BRIEF.md
# Eight-Bit Accumulator Execute Unit

This block executes the register and literal subset of a 12-bit-opcode, 8-bit microcontroller. It takes one instruction word each clock. It holds the W accumulator and the five status flags: carry, digit carry, zero, time-out and power-down. A 32-entry file register array sits outside the block. The unit reads it through a combinational port addressed by the low five opcode bits, and writes it through a one-cycle write strobe. The result goes to W or to the file register. The choice is fixed by the opcode, or by a destination bit for the two-operand register forms.

A configuration input selects how add and subtract treat the carry. When it is low, ADD folds the current carry in and SUB folds the inverted carry in as a borrow. When it is high, both operations ignore the old carry.

The increment-and-skip and decrement-and-skip forms raise a skip flag for one cycle when their result is zero. The instruction word presented during that cycle is discarded, so the skipping instruction costs two cycles. The watchdog clear form sets the time-out and power-down flags and strobes a watchdog clear output.

Top module: `mcu_exec_core`

## Requirements
- R1: During and straight after reset, W is 0x00, all five flags are 0, and skip_o, wdt_clr_o and fr_we_o are 0.
- R2: Register logic and add forms are coded 0001_ood_fffff, with oo = 00 OR, 01 AND, 10 XOR, 11 ADD. The result of W op fr goes to W when d=0 and to file register f when d=1. OR, AND and XOR change only Z.
- R3: Literal forms 1101 (OR), 1110 (AND) and 1111 (XOR) combine W with the low byte of the opcode. The result always goes to W, fr_we_o stays 0, and only Z changes.
- R4: ADD sets C to the carry out of bit 7, DC to the carry out of bit 3, and Z when the 8-bit result is zero. The old C is added when carry_mode_i=0 and is not added when carry_mode_i=1.
- R5: SUB fr,W (0000_101f_ffff) writes fr-W to the file register. C=1 means no borrow, and DC=1 means no borrow out of bit 3. When carry_mode_i=0, a further 1 is subtracted if the old C is 0.
- R6: NOT fr (0010_011), INC fr (0010_101), DEC fr (0000_111), CLR fr (0000_011) and CLR W (0000_0100_0000) change only Z. NOT complements the register, and both clears write 0 and set Z.
- R7: INCSZ (0011_111) and DECSZ (0010_111) write the result back and change no flags. When the result is zero, skip_o is 1 in the next cycle and the instruction presented in that cycle changes nothing.
- R8: RL (0011_011) computes {fr[6:0],C} and RR (0011_001) computes {C,fr[7:1]}. C takes the bit shifted out, and no other flag changes.
- R9: SWAP (0011_101) exchanges the nibbles of the file register and changes no flag.
- R10: CLR !WDT (0000_0000_0100) sets TO and PD to 1. wdt_clr_o is 1 for exactly the following cycle, and W and the other flags do not change.
- R11: Any opcode outside the forms above changes neither W nor the flags nor any file register.
- R12: fr_addr_o equals opcode bits 4:0. fr_we_o is 1 only when the executed result goes to a file register, and it is 0 in a skipped slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 12 | Instruction word for this cycle |
| carry_mode_i | input | 1 | 0: add and subtract use the old carry; 1: they ignore it |
| fr_rdata_i | input | 8 | Read data of the addressed file register |
| fr_addr_o | output | 5 | File register address |
| fr_wdata_o | output | 8 | File register write data |
| fr_we_o | output | 1 | File register write strobe |
| w_o | output | 8 | W accumulator |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit carry flag |
| z_o | output | 1 | Zero flag |
| to_o | output | 1 | Time-out flag |
| pd_o | output | 1 | Power-down flag |
| skip_o | output | 1 | Current slot is skipped |
| wdt_clr_o | output | 1 | Watchdog clear pulse |

## Verification
The bench drives DECSZ down to zero and INCSZ across 0xFF, then puts a state-changing instruction in the skipped slot. A design that executed that slot, or that let INCSZ touch Z, would show a wrong W, a wrong flag or a spurious watchdog pulse. ADD and SUB are run in both carry modes with the old C set and cleared, and with operands chosen to cross the nibble boundary and the byte boundary. A design that ignored the mode bit, or that inverted the borrow sense, would give a wrong result, C or DC. Unused opcodes and a long pseudo-random opcode stream catch decode holes, such as a register form accepted with its destination bit clear or a stray write strobe.

// File: rtl/exe_pkg.sv
// Shared widths and decode types for the execute unit.
// Assumes a 12-bit opcode, 8-bit data and a 5-bit file address.
package exe_pkg;
    localparam int INSTR_W = 12;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int NIB_W   = DATA_W / 2;

    typedef enum logic [3:0] {
        OP_NOP, OP_OR, OP_AND, OP_XOR, OP_ADD, OP_SUB, OP_CLR,
        OP_NOT, OP_INC, OP_DEC, OP_RL, OP_RR, OP_SWAP, OP_CLRWDT
    } op_e;

    typedef struct packed {
        op_e  op;
        logic use_lit;  // operand is the opcode low byte
        logic wr_w;     // result to W
        logic wr_fr;    // result to file register
        logic upd_z;
        logic upd_c;
        logic upd_dc;
        logic skip_z;   // request skip when the result is zero
    } dec_t;
endpackage

// File: rtl/exe_decode.sv
// Opcode decoder: maps an instruction word to an operation and
// its write-back and flag controls. Unlisted words decode to NOP.
module exe_decode
    import exe_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Pattern match on the opcode groups.
    always_comb begin
        dec = '{op: OP_NOP, default: 1'b0};
        unique case (instr[11:8])
            4'b0000: begin
                if (instr == 12'h004) begin
                    dec.op = OP_CLRWDT;
                end else if (instr == 12'h040) begin
                    dec.op = OP_CLR; dec.wr_w = 1'b1; dec.upd_z = 1'b1;
                end else begin
                    case (instr[7:5])
                        3'b011: begin dec.op = OP_CLR; dec.wr_fr = 1'b1; dec.upd_z = 1'b1; end
                        3'b101: begin
                            dec.op = OP_SUB; dec.wr_fr = 1'b1;
                            dec.upd_z = 1'b1; dec.upd_c = 1'b1; dec.upd_dc = 1'b1;
                        end
                        3'b111: begin dec.op = OP_DEC; dec.wr_fr = 1'b1; dec.upd_z = 1'b1; end
                        default: ;
                    endcase
                end
            end
            4'b0001: begin
                case (instr[7:6])
                    2'b00:   dec.op = OP_OR;
                    2'b01:   dec.op = OP_AND;
                    2'b10:   dec.op = OP_XOR;
                    default: begin dec.op = OP_ADD; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; end
                endcase
                dec.wr_fr = instr[5];
                dec.wr_w  = ~instr[5];
                dec.upd_z = 1'b1;
            end
            4'b0010: begin
                case (instr[7:5])
                    3'b011: begin dec.op = OP_NOT; dec.wr_fr = 1'b1; dec.upd_z = 1'b1; end
                    3'b101: begin dec.op = OP_INC; dec.wr_fr = 1'b1; dec.upd_z = 1'b1; end
                    3'b111: begin dec.op = OP_DEC; dec.wr_fr = 1'b1; dec.skip_z = 1'b1; end
                    default: ;
                endcase
            end
            4'b0011: begin
                case (instr[7:5])
                    3'b001: begin dec.op = OP_RR;   dec.wr_fr = 1'b1; dec.upd_c = 1'b1; end
                    3'b011: begin dec.op = OP_RL;   dec.wr_fr = 1'b1; dec.upd_c = 1'b1; end
                    3'b101: begin dec.op = OP_SWAP; dec.wr_fr = 1'b1; end
                    3'b111: begin dec.op = OP_INC;  dec.wr_fr = 1'b1; dec.skip_z = 1'b1; end
                    default: ;
                endcase
            end
            4'b1101, 4'b1110, 4'b1111: begin
                dec.op      = (instr[9:8] == 2'b01) ? OP_OR :
                              (instr[9:8] == 2'b10) ? OP_AND : OP_XOR;
                dec.use_lit = 1'b1;
                dec.wr_w    = 1'b1;
                dec.upd_z   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exe_alu.sv
// Combinational datapath: computes the result and carry flags for
// one operation. Assumes operand a is the file register or literal.
module exe_alu
    import exe_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] w,
    input  logic              c_in,
    input  logic              carry_mode,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              dc_out
);
    logic              sub;
    logic              cin;
    logic [DATA_W-1:0] b;
    logic [DATA_W:0]   full;
    logic [NIB_W:0]    low;

    // Shared adder: subtraction is a + ~w + carry-in.
    always_comb begin
        sub  = (op == OP_SUB);
        b    = sub ? ~w : w;
        cin  = sub ? (carry_mode | c_in) : (~carry_mode & c_in);
        full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        low  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    end

    // Result and flag selection by operation.
    always_comb begin
        res    = a;
        c_out  = c_in;
        dc_out = low[NIB_W];
        case (op)
            OP_OR:   res = a | w;
            OP_AND:  res = a & w;
            OP_XOR:  res = a ^ w;
            OP_ADD, OP_SUB: begin res = full[DATA_W-1:0]; c_out = full[DATA_W]; end
            OP_CLR:  res = '0;
            OP_NOT:  res = ~a;
            OP_INC:  res = a + 1'b1;
            OP_DEC:  res = a - 1'b1;
            OP_RL:   begin res = {a[DATA_W-2:0], c_in}; c_out = a[DATA_W-1]; end
            OP_RR:   begin res = {c_in, a[DATA_W-1:1]}; c_out = a[0]; end
            OP_SWAP: res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
            default: ;
        endcase
    end
endmodule

// File: rtl/mcu_exec_core.sv
// Execute unit top: decodes one instruction per cycle, runs it through
// the datapath, and updates W, the flags, the external file register,
// the skip slot and the watchdog strobe. Assumes fr_rdata_i is a
// combinational read of fr_addr_o.
module mcu_exec_core
    import exe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               carry_mode_i,
    input  logic [DATA_W-1:0]  fr_rdata_i,
    output logic [ADDR_W-1:0]  fr_addr_o,
    output logic [DATA_W-1:0]  fr_wdata_o,
    output logic               fr_we_o,
    output logic [DATA_W-1:0]  w_o,
    output logic               c_o,
    output logic               dc_o,
    output logic               z_o,
    output logic               to_o,
    output logic               pd_o,
    output logic               skip_o,
    output logic               wdt_clr_o
);
    dec_t              dec;
    logic              exec;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] res;
    logic              alu_c;
    logic              alu_dc;
    logic              res_zero;

    exe_decode u_dec (.instr(instr_i), .dec(dec));

    exe_alu u_alu (
        .op(dec.op), .a(opnd), .w(w_o), .c_in(c_o),
        .carry_mode(carry_mode_i), .res(res), .c_out(alu_c), .dc_out(alu_dc)
    );

    // Operand select and file register port drive.
    always_comb begin
        exec       = ~skip_o;
        opnd       = dec.use_lit ? instr_i[DATA_W-1:0] : fr_rdata_i;
        res_zero   = (res == '0);
        fr_addr_o  = instr_i[ADDR_W-1:0];
        fr_wdata_o = res;
        fr_we_o    = exec & dec.wr_fr;
    end

    // Architectural state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_o <= '0; c_o <= 1'b0; dc_o <= 1'b0; z_o <= 1'b0;
            to_o <= 1'b0; pd_o <= 1'b0; skip_o <= 1'b0; wdt_clr_o <= 1'b0;
        end else begin
            skip_o    <= exec & dec.skip_z & res_zero;
            wdt_clr_o <= exec & (dec.op == OP_CLRWDT);
            if (exec) begin
                if (dec.wr_w)   w_o  <= res;
                if (dec.upd_z)  z_o  <= res_zero;
                if (dec.upd_c)  c_o  <= alu_c;
                if (dec.upd_dc) dc_o <= alu_dc;
                if (dec.op == OP_CLRWDT) begin
                    to_o <= 1'b1;
                    pd_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mcu_exec_core_chk.sv
// Assertion checker for the execute unit, bound to the top module.
module mcu_exec_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] instr_i,
    input logic        fr_we_o,
    input logic [7:0]  w_o,
    input logic        c_o,
    input logic        dc_o,
    input logic        z_o,
    input logic        to_o,
    input logic        pd_o,
    input logic        skip_o,
    input logic        wdt_clr_o
);
    a_r12_no_write_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> !fr_we_o);
    a_r7_skip_not_chained: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> !skip_o);
    a_r10_pulse_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |-> (to_o && pd_o));
    a_r3_literal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[11:10] == 2'b11 && instr_i[9:8] != 2'b00) |-> !fr_we_o);
    a_r11_nop_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i == 12'h000 && !skip_o) |=> ($stable(w_o) && $stable({c_o, dc_o, z_o})));
    a_r9_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[11:5] == 7'b0011101 && !skip_o) |=> $stable({c_o, dc_o, z_o}));
endmodule

bind mcu_exec_core mcu_exec_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .fr_we_o(fr_we_o),
    .w_o(w_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o), .to_o(to_o), .pd_o(pd_o),
    .skip_o(skip_o), .wdt_clr_o(wdt_clr_o)
);

// File: tb/mcu_exec_core_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped once per instruction and
// compared against the design's outputs and the file array every cycle.
module mcu_exec_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr = 12'h000;
    logic        carry_mode = 1'b0;
    logic [4:0]  fr_addr;
    logic [7:0]  fr_wdata, w;
    logic        fr_we, c, dc, z, to, pd, skip, wdt;

    logic [7:0] env_mem [32];
    logic [7:0] fr_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state.
    logic [7:0] m_mem [32];
    logic [7:0] m_w;
    bit m_c, m_dc, m_z, m_to, m_pd, m_skip, m_wdt;

    always #2.5 clk = ~clk;

    assign fr_rdata = env_mem[fr_addr];
    always @(posedge clk) if (fr_we) env_mem[fr_addr] <= fr_wdata;

    mcu_exec_core u_mcu_exec_core (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .carry_mode_i(carry_mode),
        .fr_rdata_i(fr_rdata), .fr_addr_o(fr_addr), .fr_wdata_o(fr_wdata),
        .fr_we_o(fr_we), .w_o(w), .c_o(c), .dc_o(dc), .z_o(z), .to_o(to),
        .pd_o(pd), .skip_o(skip), .wdt_clr_o(wdt)
    );

    task automatic model_exec(input logic [11:0] ins, input bit cm);
        int f, a, t, lo, cin;
        logic [7:0] r;
        a = int'(ins[4:0]);
        f = int'(m_mem[a]);
        m_wdt = 0;
        if (m_skip) begin m_skip = 0; return; end
        casez (ins)
            12'b0000_0000_0100: begin m_to = 1; m_pd = 1; m_wdt = 1; end
            12'b0000_0100_0000: begin m_w = 8'h00; m_z = 1; end
            12'b0000_011?_????: begin m_mem[a] = 8'h00; m_z = 1; end
            12'b0000_101?_????: begin
                cin = cm ? 0 : (m_c ? 0 : 1);
                t  = f - int'(m_w) - cin;
                lo = (f % 16) - (int'(m_w) % 16) - cin;
                r = t[7:0]; m_mem[a] = r; m_c = (t >= 0); m_dc = (lo >= 0); m_z = (r == 0);
            end
            12'b0000_111?_????: begin r = 8'(f - 1); m_mem[a] = r; m_z = (r == 0); end
            12'b0001_????_????: begin
                case (ins[7:6])
                    2'b00: r = 8'(f) | m_w;
                    2'b01: r = 8'(f) & m_w;
                    2'b10: r = 8'(f) ^ m_w;
                    default: begin
                        cin = (!cm && m_c) ? 1 : 0;
                        t  = f + int'(m_w) + cin;
                        lo = (f % 16) + (int'(m_w) % 16) + cin;
                        r = t[7:0]; m_c = (t > 255); m_dc = (lo > 15);
                    end
                endcase
                if (ins[5]) m_mem[a] = r; else m_w = r;
                m_z = (r == 0);
            end
            12'b0010_011?_????: begin r = ~8'(f); m_mem[a] = r; m_z = (r == 0); end
            12'b0010_101?_????: begin r = 8'(f + 1); m_mem[a] = r; m_z = (r == 0); end
            12'b0010_111?_????: begin r = 8'(f - 1); m_mem[a] = r; m_skip = (r == 0); end
            12'b0011_001?_????: begin r = {m_c, 7'(f / 2)}; m_c = (f % 2) == 1; m_mem[a] = r; end
            12'b0011_011?_????: begin r = 8'(f * 2 + (m_c ? 1 : 0)); m_c = f > 127; m_mem[a] = r; end
            12'b0011_101?_????: begin r = 8'((f % 16) * 16 + f / 16); m_mem[a] = r; end
            12'b0011_111?_????: begin r = 8'(f + 1); m_mem[a] = r; m_skip = (r == 0); end
            12'b1101_????_????: begin m_w = m_w | ins[7:0]; m_z = (m_w == 0); end
            12'b1110_????_????: begin m_w = m_w & ins[7:0]; m_z = (m_w == 0); end
            12'b1111_????_????: begin m_w = m_w ^ ins[7:0]; m_z = (m_w == 0); end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag, input logic [11:0] ins);
        bit bad = 0;
        vectors++;
        if (w !== m_w || c !== m_c || dc !== m_dc || z !== m_z || to !== m_to ||
            pd !== m_pd || skip !== m_skip || wdt !== m_wdt) bad = 1;
        for (int i = 0; i < 32; i++) if (env_mem[i] !== m_mem[i]) bad = 1;
        if (bad) begin
            errors++;
            $display("FAIL %s instr=%h: act W=%h C%b DC%b Z%b TO%b PD%b SK%b WD%b fr=%h exp W=%h C%b DC%b Z%b TO%b PD%b SK%b WD%b fr=%h",
                     tag, ins, w, c, dc, z, to, pd, skip, wdt, env_mem[ins[4:0]],
                     m_w, m_c, m_dc, m_z, m_to, m_pd, m_skip, m_wdt, m_mem[ins[4:0]]);
        end
    endtask

    task automatic step(input logic [11:0] ins, input bit cm, input string tag);
        instr = ins;
        carry_mode = cm;
        model_exec(ins, cm);
        @(posedge clk);
        @(negedge clk);
        compare(tag, ins);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 32; i++) begin
            env_mem[i] = 8'((i * 37 + 5) % 256);
            m_mem[i]   = env_mem[i];
        end
        m_w = 0; m_c = 0; m_dc = 0; m_z = 0; m_to = 0; m_pd = 0; m_skip = 0; m_wdt = 0;
        repeat (3) @(negedge clk);
        compare("R1", instr);
        rst_n = 1'b1;
        step(12'h000, 0, "R1");
        // R3 literal forms
        step(12'h040, 0, "R6");
        step(12'hD5A, 0, "R3");
        step(12'hE0F, 0, "R3");
        step(12'hF0A, 0, "R3");
        step(12'hD3C, 0, "R3");
        // R2 register logic, both destinations
        step(12'h103, 0, "R2");
        step(12'h125, 0, "R2");
        step(12'h146, 0, "R2");
        step(12'h167, 0, "R2");
        step(12'h188, 0, "R2");
        step(12'h1A9, 0, "R2");
        // R4 add: byte and nibble carries, both carry modes
        step(12'h040, 0, "R6");
        step(12'hDFF, 0, "R4");
        step(12'h1C4, 1, "R4");
        step(12'h1E4, 0, "R4");
        step(12'h1EA, 0, "R4");
        step(12'h1CB, 1, "R4");
        step(12'h1EC, 0, "R4");
        // R5 subtract both modes, with and without borrow
        step(12'h0A5, 1, "R5");
        step(12'h0A6, 0, "R5");
        step(12'h0A7, 0, "R5");
        step(12'h040, 0, "R6");
        step(12'h0A8, 0, "R5");
        step(12'h0A8, 1, "R5");
        // R6 unary forms
        step(12'h269, 0, "R6");
        step(12'h06A, 0, "R6");
        step(12'h2AA, 0, "R6");
        step(12'h0EA, 0, "R6");
        step(12'h0EA, 0, "R6");
        // R8 rotates, R9 swap
        step(12'h36B, 0, "R8");
        step(12'h36B, 0, "R8");
        step(12'h32C, 0, "R8");
        step(12'h32D, 0, "R8");
        step(12'h3AE, 0, "R9");
        // R7 skip on zero; skipped slot must not act
        step(12'h040, 0, "R7");
        step(12'hD01, 0, "R7");
        step(12'h062, 0, "R7");
        step(12'h122, 0, "R7");
        step(12'h2E2, 0, "R7");
        step(12'hDFF, 0, "R7");
        step(12'hDFF, 0, "R7");
        step(12'h063, 0, "R7");
        step(12'h123, 0, "R7");
        step(12'h3E3, 0, "R7");
        step(12'h004, 0, "R7");
        step(12'h3E3, 0, "R7");
        // R10 watchdog clear
        step(12'h004, 0, "R10");
        step(12'h000, 0, "R10");
        // R11 unused opcodes
        step(12'h245, 0, "R11");
        step(12'hC33, 0, "R11");
        step(12'h805, 0, "R11");
        step(12'h085, 0, "R11");
        step(12'h30F, 0, "R11");
        // R12 pseudo-random stream
        for (int n = 0; n < 400; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(seed[27:16], seed[30], "R12");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule